// File: doc/BRIEF.md
# DMA Controller Register Interface

This block is the byte-wide programming side of a four-channel DMA controller. A host reaches it through a small port address, separate read and write strobes and an 8-bit data bus. For each channel it keeps a 16-bit base address, a 16-bit base count, their current copies and a 6-bit mode word. It also keeps a channel mask, terminal-count flags and a single byte-pointer flip-flop. That flip-flop splits every 16-bit access into a low byte followed by a high byte.

Several command ports in the upper half of the port space act only when they are written: the data on the bus is ignored. The transfer engine uses this block in two ways. It reads each channel's decoded mode fields, its enable state (the inverse of the mask) and its base and current registers. It can also overwrite a channel's current address and count, and it reports terminal counts and live requests back into the status byte.

Top module: `dmac_regfile`

## Requirements
- R1: After reset every mask bit is set (ch_enable is 4'b0000), the byte pointer is clear, and all address, count and mode registers are zero. A status read with drq low returns 8'h00.
- R2: Channel n has its address at port 2n and its count at port 2n+1. One byte pointer is shared by all eight of these ports. Any read or write of them uses the low byte when the pointer is clear and the high byte when it is set, and then toggles the pointer.
- R3: A high-byte write to an address or count copies the whole new base value into that channel's current register. A low-byte write changes only the base register.
- R4: Reading an address or count port returns the selected byte of the current register, not of the base register.
- R5: A write to port 10 selects the channel with data[1:0]. data[2]=1 sets that channel's mask bit and data[2]=0 clears it.
- R6: A write to port 15 loads the mask from data[3:0].
- R7: Any write to port 12 clears the byte pointer. Any write to port 13 clears the pointer and sets all mask bits. Any write to port 14 clears all mask bits.
- R8: A write to port 11 stores data[7:2] as the mode of the channel given by data[1:0]. The fields are decoded as follows: data[7:6] is ch_opmode, data[5] is ch_dec, data[4] is ch_autoinit and data[3:2] is ch_xtype.
- R9: Port 8 reads as {drq[3:0], tc[3:0]}. A tc_set bit sets the matching terminal-count flag.
- R10: A read of port 8 clears the terminal-count flags and returns the value they had before the clear. A tc_set bit in the same cycle as that read leaves its flag set.
- R11: Port 9 and ports 10 to 15 read as 8'h00. Writes to ports 8 and 9 change no state.
- R12: With eng_we high, eng_addr and eng_cnt load the current registers of channel eng_ch. A host high-byte write to the same register in the same cycle takes precedence.
- R13: When wr_en and rd_en are both high, only the write acts: the pointer toggles once and a status read clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_addr | input | PAW | Register port number |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for port_addr |
| drq | input | NCH | Live request per channel |
| tc_set | input | NCH | Terminal-count event per channel |
| eng_we | input | 1 | Engine write of current registers |
| eng_ch | input | CHW | Channel for eng_we |
| eng_addr | input | 16 | New current address |
| eng_cnt | input | 16 | New current count |
| base_addr_o | output | NCH*16 | Base addresses, channel 0 in the low bits |
| base_cnt_o | output | NCH*16 | Base counts |
| cur_addr_o | output | NCH*16 | Current addresses |
| cur_cnt_o | output | NCH*16 | Current counts |
| ch_opmode | output | 2*NCH | Operating mode per channel |
| ch_dec | output | NCH | Address decrement per channel |
| ch_autoinit | output | NCH | Auto-reload per channel |
| ch_xtype | output | 2*NCH | Transfer type per channel |
| ch_enable | output | NCH | Channel unmasked |

## Verification
The bench builds the block with its default NCH=4 and PAW=4. With these values the eight register ports fill 0 to 7 and the command block fills 8 to 15. Every channel number that data[1:0] can select on the mask and mode ports therefore exists. These values also bring within reach the sharing of the byte pointer between different channels, and the collision between a host write and an engine write on one channel.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int REGW = 16;

  // offsets of the command ports above the channel register block
  typedef enum logic [2:0] {
    CMD_STATUS  = 3'd0,
    CMD_SPARE   = 3'd1,
    CMD_SMASK   = 3'd2,
    CMD_MODE    = 3'd3,
    CMD_CLRPTR  = 3'd4,
    CMD_MRESET  = 3'd5,
    CMD_CLRMASK = 3'd6,
    CMD_AMASK   = 3'd7
  } cmd_e;

  typedef struct packed {
    logic [1:0] opmode;
    logic       dec;
    logic       autoinit;
    logic [1:0] xtype;
  } mode_t;

  function automatic logic [REGW-1:0] put_byte(input logic [REGW-1:0] v,
                                               input logic hi,
                                               input logic [7:0] b);
    return hi ? {b, v[7:0]} : {v[15:8], b};
  endfunction

  function automatic logic [7:0] get_byte(input logic [REGW-1:0] v, input logic hi);
    return hi ? v[15:8] : v[7:0];
  endfunction
endpackage

// File: rtl/dmac_byteptr.sv
module dmac_byteptr (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic clear,
  output logic hi
);
  always_ff @(posedge clk) begin
    if (!rst_n)     hi <= 1'b0;
    else if (clear) hi <= 1'b0;
    else if (step)  hi <= ~hi;
  end
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_we,
  input  logic            host_cnt,
  input  logic            host_hi,
  input  logic [7:0]      host_data,
  input  logic            eng_we,
  input  logic [REGW-1:0] eng_addr,
  input  logic [REGW-1:0] eng_cnt,
  input  logic            mode_we,
  input  mode_t           mode_d,
  output logic [REGW-1:0] base_addr,
  output logic [REGW-1:0] base_cnt,
  output logic [REGW-1:0] cur_addr,
  output logic [REGW-1:0] cur_cnt,
  output mode_t           mode_q
);
  logic [REGW-1:0] new_addr, new_cnt;
  assign new_addr = put_byte(base_addr, host_hi, host_data);
  assign new_cnt  = put_byte(base_cnt, host_hi, host_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      mode_q    <= '0;
    end else begin
      if (eng_we) begin
        cur_addr <= eng_addr;
        cur_cnt  <= eng_cnt;
      end
      // host write placed last: it wins over the engine
      if (host_we) begin
        if (host_cnt) begin
          base_cnt <= new_cnt;
          if (host_hi) cur_cnt <= new_cnt;
        end else begin
          base_addr <= new_addr;
          if (host_hi) cur_addr <= new_addr;
        end
      end
      if (mode_we) mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/dmac_ctl.sv
module dmac_ctl #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           smask_we,
  input  logic           amask_we,
  input  logic           mreset,
  input  logic           clrmask,
  input  logic [3:0]     wdata_lo,
  input  logic           tc_clr,
  input  logic [NCH-1:0] tc_set,
  input  logic [NCH-1:0] drq,
  output logic [NCH-1:0] mask,
  output logic [NCH-1:0] tc,
  output logic [7:0]     status
);
  assign status = {4'(drq), 4'(tc)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '1;
      tc   <= '0;
    end else begin
      if (mreset)        mask <= '1;
      else if (clrmask)  mask <= '0;
      else if (amask_we) mask <= wdata_lo[NCH-1:0];
      else if (smask_we) begin
        for (int i = 0; i < NCH; i++)
          if (wdata_lo[1:0] == 2'(i)) mask[i] <= wdata_lo[2];
      end
      tc <= (tc_clr ? '0 : tc) | tc_set;
    end
  end
endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
  import dmac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int PAW = 4,
  parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PAW-1:0]      port_addr,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [7:0]          wdata,
  output logic [7:0]          rd_data,
  input  logic [NCH-1:0]      drq,
  input  logic [NCH-1:0]      tc_set,
  input  logic                eng_we,
  input  logic [CHW-1:0]      eng_ch,
  input  logic [15:0]         eng_addr,
  input  logic [15:0]         eng_cnt,
  output logic [NCH*16-1:0]   base_addr_o,
  output logic [NCH*16-1:0]   base_cnt_o,
  output logic [NCH*16-1:0]   cur_addr_o,
  output logic [NCH*16-1:0]   cur_cnt_o,
  output logic [2*NCH-1:0]    ch_opmode,
  output logic [NCH-1:0]      ch_dec,
  output logic [NCH-1:0]      ch_autoinit,
  output logic [2*NCH-1:0]    ch_xtype,
  output logic [NCH-1:0]      ch_enable
);
  localparam logic [PAW-1:0] CMD_BASE = PAW'(2 * NCH);

  // decode
  logic           is_chreg, is_cmd, rd_act;
  logic [PAW-1:0] cmd_off;
  cmd_e           cmd;
  logic [CHW-1:0] ch_sel;

  assign is_chreg = port_addr < CMD_BASE;
  assign cmd_off  = port_addr - CMD_BASE;
  assign is_cmd   = !is_chreg && (cmd_off < PAW'(8));
  assign cmd      = cmd_e'(cmd_off[2:0]);
  assign ch_sel   = port_addr[CHW:1];
  assign rd_act   = rd_en && !wr_en;

  // named internal events
  logic ptr_step, ptr_clear, ptr_hi, tc_clr;
  logic cmd_wr;
  assign cmd_wr    = wr_en && is_cmd;
  assign ptr_step  = is_chreg && (wr_en || rd_en);
  assign ptr_clear = cmd_wr && (cmd == CMD_CLRPTR || cmd == CMD_MRESET);
  assign tc_clr    = rd_act && is_cmd && (cmd == CMD_STATUS);

  dmac_byteptr u_ptr (
    .clk(clk), .rst_n(rst_n), .step(ptr_step), .clear(ptr_clear), .hi(ptr_hi)
  );

  logic [NCH-1:0] mask_q, tc_q;
  logic [7:0]     status;

  dmac_ctl #(.NCH(NCH)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .smask_we(cmd_wr && cmd == CMD_SMASK),
    .amask_we(cmd_wr && cmd == CMD_AMASK),
    .mreset(cmd_wr && cmd == CMD_MRESET),
    .clrmask(cmd_wr && cmd == CMD_CLRMASK),
    .wdata_lo(wdata[3:0]),
    .tc_clr(tc_clr), .tc_set(tc_set), .drq(drq),
    .mask(mask_q), .tc(tc_q), .status(status)
  );

  assign ch_enable = ~mask_q;

  logic [15:0] cur_a [NCH];
  logic [15:0] cur_c [NCH];
  mode_t       mode_w;
  assign mode_w = mode_t'(wdata[7:2]);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    mode_t m;
    dmac_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .host_we(wr_en && is_chreg && ch_sel == CHW'(g)),
      .host_cnt(port_addr[0]), .host_hi(ptr_hi), .host_data(wdata),
      .eng_we(eng_we && eng_ch == CHW'(g)),
      .eng_addr(eng_addr), .eng_cnt(eng_cnt),
      .mode_we(cmd_wr && cmd == CMD_MODE && wdata[1:0] == 2'(g)),
      .mode_d(mode_w),
      .base_addr(base_addr_o[g*16 +: 16]),
      .base_cnt(base_cnt_o[g*16 +: 16]),
      .cur_addr(cur_a[g]),
      .cur_cnt(cur_c[g]),
      .mode_q(m)
    );
    assign cur_addr_o[g*16 +: 16] = cur_a[g];
    assign cur_cnt_o[g*16 +: 16]  = cur_c[g];
    assign ch_opmode[2*g +: 2]    = m.opmode;
    assign ch_dec[g]              = m.dec;
    assign ch_autoinit[g]         = m.autoinit;
    assign ch_xtype[2*g +: 2]     = m.xtype;
  end

  // read mux
  always_comb begin
    rd_data = 8'h00;
    if (is_chreg)
      rd_data = get_byte(port_addr[0] ? cur_c[ch_sel] : cur_a[ch_sel], ptr_hi);
    else if (is_cmd && cmd == CMD_STATUS)
      rd_data = status;
  end
endmodule

// File: rtl/dmac_regfile_chk.sv
module dmac_regfile_chk #(
  parameter int NCH = 4,
  parameter int PAW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [PAW-1:0] port_addr,
  input logic           wr_en,
  input logic           rd_en,
  input logic [7:0]     wdata,
  input logic [7:0]     rd_data,
  input logic [NCH-1:0] tc_set,
  input logic           ptr_hi,
  input logic           ptr_step,
  input logic           ptr_clear,
  input logic [NCH-1:0] mask_q,
  input logic [NCH-1:0] tc_q
);
  localparam logic [PAW-1:0] P_STATUS  = PAW'(2 * NCH + 0);
  localparam logic [PAW-1:0] P_SPARE   = PAW'(2 * NCH + 1);
  localparam logic [PAW-1:0] P_MRESET  = PAW'(2 * NCH + 5);
  localparam logic [PAW-1:0] P_CLRMASK = PAW'(2 * NCH + 6);
  localparam logic [PAW-1:0] P_AMASK   = PAW'(2 * NCH + 7);

  assert_ptr_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_step && !ptr_clear) |=> (ptr_hi != $past(ptr_hi)));

  assert_mreset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port_addr == P_MRESET) |=> (mask_q == '1 && !ptr_hi));

  assert_clrmask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port_addr == P_CLRMASK) |=> (mask_q == '0));

  assert_amask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port_addr == P_AMASK) |=> (mask_q == $past(wdata[NCH-1:0])));

  assert_status_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && port_addr == P_STATUS) |=> (tc_q == $past(tc_set)));

  assert_spare_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && port_addr == P_SPARE) |-> (rd_data == 8'h00));

  assert_write_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && port_addr == P_STATUS) |=> ((tc_q & $past(tc_q)) == $past(tc_q)));
endmodule

bind dmac_regfile dmac_regfile_chk #(.NCH(NCH), .PAW(PAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rd_data(rd_data), .tc_set(tc_set), .ptr_hi(ptr_hi),
  .ptr_step(ptr_step), .ptr_clear(ptr_clear), .mask_q(mask_q), .tc_q(tc_q)
);

// File: tb/tb_dmac_regfile.sv
module tb_dmac_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic           rst_n = 1'b0;
  logic [3:0]     port_addr = '0;
  logic           wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]     wdata = '0;
  logic [7:0]     rd_data;
  logic [NCH-1:0] drq = '0, tc_set = '0;
  logic           eng_we = 1'b0;
  logic [1:0]     eng_ch = '0;
  logic [15:0]    eng_addr = '0, eng_cnt = '0;
  logic [NCH*16-1:0] base_addr_o, base_cnt_o, cur_addr_o, cur_cnt_o;
  logic [2*NCH-1:0]  ch_opmode, ch_xtype;
  logic [NCH-1:0]    ch_dec, ch_autoinit, ch_enable;

  dmac_regfile dut (
    .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rd_data(rd_data), .drq(drq), .tc_set(tc_set),
    .eng_we(eng_we), .eng_ch(eng_ch), .eng_addr(eng_addr), .eng_cnt(eng_cnt),
    .base_addr_o(base_addr_o), .base_cnt_o(base_cnt_o),
    .cur_addr_o(cur_addr_o), .cur_cnt_o(cur_cnt_o),
    .ch_opmode(ch_opmode), .ch_dec(ch_dec), .ch_autoinit(ch_autoinit),
    .ch_xtype(ch_xtype), .ch_enable(ch_enable)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] p, input logic [7:0] d);
    @(negedge clk);
    port_addr = p; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] p, input logic [7:0] e, input string tag);
    @(negedge clk);
    port_addr = p; rd_en = 1'b1;
    #1 chk(tag, 32'(rd_data), 32'(e));
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  // {write, port, data, expected read, requirement}
  typedef struct packed {
    logic       w;
    logic [3:0] p;
    logic [7:0] d;
    logic [7:0] e;
    logic [3:0] r;
  } vec_t;

  localparam vec_t VEC [19] = '{
    '{1'b1, 4'd0,  8'h34, 8'h00, 4'd2},   // R2 ch0 addr low
    '{1'b1, 4'd0,  8'h12, 8'h00, 4'd3},   // R3 high byte, copy to current
    '{1'b0, 4'd0,  8'h00, 8'h34, 4'd4},   // R4
    '{1'b0, 4'd0,  8'h00, 8'h12, 4'd4},
    '{1'b1, 4'd3,  8'hCD, 8'h00, 4'd2},   // ch1 count low
    '{1'b0, 4'd2,  8'h00, 8'h00, 4'd2},   // shared pointer: high byte of ch1 addr
    '{1'b0, 4'd3,  8'h00, 8'h00, 4'd3},   // low write left current alone
    '{1'b1, 4'd3,  8'hAB, 8'h00, 4'd3},
    '{1'b0, 4'd3,  8'h00, 8'hCD, 4'd4},
    '{1'b0, 4'd3,  8'h00, 8'hAB, 4'd4},
    '{1'b1, 4'd7,  8'h55, 8'h00, 4'd2},
    '{1'b1, 4'd12, 8'h00, 8'h00, 4'd7},   // R7 clear pointer
    '{1'b1, 4'd7,  8'h66, 8'h00, 4'd7},
    '{1'b1, 4'd7,  8'h77, 8'h00, 4'd7},
    '{1'b0, 4'd7,  8'h00, 8'h66, 4'd7},
    '{1'b0, 4'd7,  8'h00, 8'h77, 4'd7},
    '{1'b0, 4'd8,  8'h00, 8'h00, 4'd9},
    '{1'b0, 4'd9,  8'h00, 8'h00, 4'd11},
    '{1'b0, 4'd11, 8'h00, 8'h00, 4'd11}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    #1 chk("R1 enable", 32'(ch_enable), 32'h0);
    chk("R1 mode", 32'({ch_opmode, ch_dec, ch_autoinit, ch_xtype}), 32'h0);
    chk("R1 current", 32'(cur_addr_o[15:0]), 32'h0);
    rd(4'd8, 8'h00, "R1 status");

    for (int i = 0; i < 19; i++) begin
      if (VEC[i].w) wr(VEC[i].p, VEC[i].d);
      else rd(VEC[i].p, VEC[i].e, $sformatf("R%0d vec%0d", VEC[i].r, i));
    end
    chk("R3 base ch0", 32'(base_addr_o[15:0]), 32'h1234);
    chk("R3 base ch3 cnt", 32'(base_cnt_o[63:48]), 32'h7766);

    // R5 single mask
    wr(4'd10, 8'h00); chk("R5 clear ch0", 32'(ch_enable), 32'h1);
    wr(4'd10, 8'h02); chk("R5 clear ch2", 32'(ch_enable), 32'h5);
    wr(4'd10, 8'h04); chk("R5 set ch0", 32'(ch_enable), 32'h4);
    // R6 all mask
    wr(4'd15, 8'hFA); chk("R6 load", 32'(ch_enable), 32'h5);
    // R7 master reset and clear mask
    wr(4'd0, 8'h99);
    wr(4'd13, 8'h00); chk("R7 master reset mask", 32'(ch_enable), 32'h0);
    rd(4'd0, 8'h34, "R7 pointer cleared");
    wr(4'd14, 8'h00); chk("R7 clear mask", 32'(ch_enable), 32'hF);
    wr(4'd12, 8'h00);

    // R8 mode: data 1011_0110 -> ch2 opmode 2, dec 1, autoinit 1, xtype 1
    wr(4'd11, 8'hB6);
    chk("R8 opmode", 32'(ch_opmode), 32'h20);
    chk("R8 dec", 32'(ch_dec), 32'h4);
    chk("R8 autoinit", 32'(ch_autoinit), 32'h4);
    chk("R8 xtype", 32'(ch_xtype), 32'h10);

    // R9 / R10 status
    drq = 4'b1000;
    @(negedge clk) tc_set = 4'b0101;
    @(negedge clk) tc_set = 4'b0000;
    rd(4'd8, 8'h85, "R9 status");
    rd(4'd8, 8'h80, "R10 cleared");
    @(negedge clk);
    port_addr = 4'd8; rd_en = 1'b1; tc_set = 4'b0010;
    #1 chk("R10 pre-clear value", 32'(rd_data), 32'h80);
    @(posedge clk); #1;
    rd_en = 1'b0; tc_set = '0;
    rd(4'd8, 8'h82, "R10 set wins over clear");
    rd(4'd8, 8'h80, "R10 cleared again");

    // R11 unmapped
    wr(4'd8, 8'hFF); wr(4'd9, 8'hFF);
    chk("R11 mask untouched", 32'(ch_enable), 32'hF);
    rd(4'd8, 8'h80, "R11 status untouched");
    rd(4'd13, 8'h00, "R11 read port13");
    rd(4'd15, 8'h00, "R11 read port15");
    rd(4'd0, 8'h34, "R11 pointer untouched low");
    rd(4'd0, 8'h12, "R11 pointer untouched high");

    // R12 engine update
    @(negedge clk);
    eng_we = 1'b1; eng_ch = 2'd1; eng_addr = 16'hBEEF; eng_cnt = 16'h0010;
    @(posedge clk); #1 eng_we = 1'b0;
    rd(4'd2, 8'hEF, "R12 engine addr low");
    rd(4'd2, 8'hBE, "R12 engine addr high");
    rd(4'd3, 8'h10, "R12 engine cnt low");
    rd(4'd3, 8'h00, "R12 engine cnt high");
    chk("R12 base untouched", 32'(base_cnt_o[31:16]), 32'hABCD);
    wr(4'd2, 8'h11);
    @(negedge clk);
    port_addr = 4'd2; wdata = 8'h22; wr_en = 1'b1;
    eng_we = 1'b1; eng_ch = 2'd1; eng_addr = 16'h5555; eng_cnt = 16'h0007;
    @(posedge clk); #1 wr_en = 1'b0; eng_we = 1'b0;
    chk("R12 host wins", 32'(cur_addr_o[31:16]), 32'h2211);
    chk("R12 engine count kept", 32'(cur_cnt_o[31:16]), 32'h0007);

    // R13 both strobes
    @(negedge clk) tc_set = 4'b0001;
    @(negedge clk) tc_set = 4'b0000;
    @(negedge clk);
    port_addr = 4'd8; wr_en = 1'b1; rd_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0; rd_en = 1'b0;
    rd(4'd8, 8'h81, "R13 read suppressed");
    @(negedge clk);
    port_addr = 4'd0; wdata = 8'h44; wr_en = 1'b1; rd_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0; rd_en = 1'b0;
    wr(4'd0, 8'h56);
    chk("R13 single toggle", 32'(cur_addr_o[15:0]), 32'h5644);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule